// File: doc/BRIEF.md
# MDIO Management Master with Link Polling

This block is the management-bus master for a group of MII-compliant PHYs. It generates the management clock (MDC) from the system clock through a programmable divider. It shifts management frames out on the bidirectional MDIO line and releases the line wherever the PHY is to drive it. The pad tri-state buffer is outside the block, so MDIO appears here as a data output, an output enable and a data input.

Two sources share the single management line. Software loads a command (read or write, PHY address, register address, write data) and pulses a start strobe. The block then raises `busy`, runs the frame and, for a read, places the returned word on `rd_data` before `busy` drops. When no command is waiting, a background engine reads the link-status register of each port's PHY in turn, at the address software has set for that port. It copies the link bit into a per-port `link_up` output. A waiting command wins the next frame slot but never cuts short a frame that is already on the wire.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 consecutive MDC periods in which MDIO is driven (`mdio_oe`=1) at logic one.
- R2: After the preamble come the start pattern 0,1 and then the opcode: 1,0 for a read and 0,1 for a write.
- R3: The opcode is followed by the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R4: In a write frame the master drives the turnaround as 1 then 0, followed by the 16 write-data bits MSB first, keeping `mdio_oe` high for all 64 bits.
- R5: In a read frame `mdio_oe` is low from the first turnaround bit (bit 46 of 64) to the end. The 16 bits the PHY returns after the turnaround are assembled MSB first and appear on `rd_data` when `busy` falls.
- R6: `mdc` stays in each level for `mdc_div`+1 system clocks. `mdio_out` and `mdio_oe` change only at a falling edge of `mdc`. MDIO input is sampled at the rising edge.
- R7: `busy` goes high one clock after an accepted `cmd_start` and stays high until that command's frame ends. A `cmd_start` that arrives while `busy` is high is ignored.
- R8: With no command waiting, the block reads register 1 of each port's PHY, at the address in that port's 5-bit slice of `poll_phy_addr` (port 0 in the low bits), cycling through ports 0 to N-1. It sets `link_up[port]` to bit 2 of the returned word. `link_up` changes at no other time.
- R9: A command accepted while a frame is in progress is sent in the very next frame. The frame in progress runs to completion unaltered.
- R10: During reset `mdc` is low, `mdio_oe` is 0, `busy` is 0, and `link_up` and `rd_data` are all zero.
- R11: After the last bit of a frame, MDIO is released (`mdio_oe`=0) for at least one full MDC period before the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_div | input | DIV_W | MDC half-period in system clocks, minus one |
| cmd_start | input | 1 | Start strobe for a software command |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Data for a write command |
| poll_phy_addr | input | NPORTS*5 | Polling PHY address per port, port 0 in bits 4:0 |
| mdio_in | input | 1 | MDIO level seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive when enabled |
| mdio_oe | output | 1 | MDIO output enable for the pad buffer |
| rd_data | output | 16 | Result of the last software read |
| busy | output | 1 | Software command waiting or in progress |
| link_up | output | NPORTS | Last polled link status per port |

## Verification
The bench injects a command while a poll frame is on the wire and checks that it takes the next slot. An engine that preempted would truncate the poll frame and fail its format check, and one that lagged would let another poll slip in first. A second strobe during `busy` must not replace the latched command: a design that reloads would send the wrong address and raise `busy` again afterwards. A PHY model answers every read, and each frame is checked for the turnaround handling. A design that drives during a read turnaround, or assembles data LSB first, shows it on `mdio_oe` or `rd_data`. Link bits are set per PHY address across a non-power-of-two port count, which exposes a poll index that fails to wrap or a link bit taken from the wrong position. MDC high time is measured at several divider settings, including zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int DATA_POS  = TA_POS + 2;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int LINK_REG  = 1;
    localparam int LINK_BIT  = 2;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } opc_e;

    typedef struct packed {
        logic              rd;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    // Whole frame as a vector; the MSB goes out first.
    function automatic logic [FRAME_LEN-1:0] frame_image(mgmt_req_t r);
        opc_e              op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        op = r.rd ? OPC_READ : OPC_WRITE;
        ta = r.rd ? 2'b11 : 2'b10;
        d  = r.rd ? '1 : r.wdata;
        return {{PRE_LEN{1'b1}}, 2'b01, op, r.phy, r.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = (cnt >= div_half);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: MDC holds its level until the divider count is used up
    assert_mdc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt < div_half) |=> $stable(mdc));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_stb,
    input  logic              rise_stb,
    input  logic              req_valid,
    input  mgmt_req_t         req,
    input  logic              mdio_in,
    output logic              accept,
    output logic              done,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_word
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);

    logic                 active;
    logic                 is_rd;
    logic [IDX_W-1:0]     bit_idx;
    logic [IDX_W-1:0]     nxt_idx;
    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] img;

    assign img     = frame_image(req);
    assign nxt_idx = bit_idx + 1'b1;
    // A new frame may only begin on a falling edge after the line has idled.
    assign accept  = fall_stb && !active && req_valid;
    assign done    = fall_stb && active && (bit_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            is_rd    <= 1'b0;
            bit_idx  <= '0;
            shreg    <= '0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            rd_word  <= '0;
        end else begin
            if (accept) begin
                active   <= 1'b1;
                is_rd    <= req.rd;
                bit_idx  <= '0;
                mdio_out <= img[FRAME_LEN-1];
                shreg    <= {img[FRAME_LEN-2:0], 1'b0};
                mdio_oe  <= 1'b1;
            end else if (done) begin
                active   <= 1'b0;
                mdio_out <= 1'b1;
                mdio_oe  <= 1'b0;
            end else if (fall_stb && active) begin
                bit_idx  <= nxt_idx;
                mdio_out <= shreg[FRAME_LEN-1];
                shreg    <= {shreg[FRAME_LEN-2:0], 1'b0};
                mdio_oe  <= !(is_rd && (nxt_idx >= TA_IDX));
            end
            if (rise_stb && active && is_rd && (bit_idx >= DATA_IDX)) begin
                rd_word <= {rd_word[DATA_W-2:0], mdio_in};
            end
        end
    end

    // R6: pad outputs move only on an MDC falling edge
    assert_pad_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !fall_stb |=> ($stable(mdio_out) && $stable(mdio_oe)));

    // R1: preamble bits are driven ones
    assert_preamble_R1: assert property (@(posedge clk) disable iff (rst)
        (active && (bit_idx < PRE_IDX)) |-> (mdio_oe && mdio_out));

    // R5: read frames leave the line to the PHY from the turnaround on
    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        (active && is_rd && (bit_idx >= TA_IDX)) |-> !mdio_oe);

    // R11: once a frame ends the line is released
    assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !mdio_oe);

endmodule

// File: rtl/mdio_sched.sv
module mdio_sched
    import mdio_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_start,
    input  logic                     cmd_rd,
    input  logic [PHY_AW-1:0]        cmd_phy,
    input  logic [REG_AW-1:0]        cmd_reg,
    input  logic [DATA_W-1:0]        cmd_wdata,
    input  logic [NPORTS*PHY_AW-1:0] poll_phy_addr,
    input  logic                     accept,
    input  logic                     done,
    input  logic [DATA_W-1:0]        rd_word,
    output mgmt_req_t                req,
    output logic                     busy,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NPORTS-1:0]        link_up
);

    localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NPORTS - 1);

    logic [PHY_AW-1:0] port_addr [NPORTS];
    logic              cpu_pend;
    mgmt_req_t         cpu_req;
    mgmt_req_t         poll_req;
    logic              own_cpu;
    logic [PIDX_W-1:0] own_port;
    logic [PIDX_W-1:0] poll_idx;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign port_addr[g] = poll_phy_addr[g*PHY_AW +: PHY_AW];
    end

    always_comb begin
        poll_req.rd    = 1'b1;
        poll_req.phy   = port_addr[poll_idx];
        poll_req.regad = REG_AW'(LINK_REG);
        poll_req.wdata = '0;
    end

    // A waiting command takes the next free slot; polls fill the rest.
    assign req  = cpu_pend ? cpu_req : poll_req;
    assign busy = cpu_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_pend <= 1'b0;
            cpu_req  <= '0;
            own_cpu  <= 1'b0;
            own_port <= '0;
            poll_idx <= '0;
            rd_data  <= '0;
            link_up  <= '0;
        end else begin
            if (accept) begin
                own_cpu  <= cpu_pend;
                own_port <= poll_idx;
            end
            if (done) begin
                if (own_cpu) begin
                    cpu_pend <= 1'b0;
                    if (cpu_req.rd) rd_data <= rd_word;
                end else begin
                    link_up[own_port] <= rd_word[LINK_BIT];
                    poll_idx <= (poll_idx == LAST_PORT) ? '0 : poll_idx + 1'b1;
                end
            end
            if (cmd_start && !cpu_pend) begin
                cpu_pend      <= 1'b1;
                cpu_req.rd    <= cmd_rd;
                cpu_req.phy   <= cmd_phy;
                cpu_req.regad <= cmd_reg;
                cpu_req.wdata <= cmd_wdata;
            end
        end
    end

    // R7: busy is held until the owning frame completes
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_pend && !(done && own_cpu)) |=> cpu_pend);

    // R7: the latched command is frozen while busy
    assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_pend && !(done && own_cpu)) |=> $stable(cpu_req));

    // R9: ownership of the line changes only when a frame is accepted
    assert_no_preempt_R9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(own_cpu) && $stable(own_port)));

    // R8: link status moves only at the end of a poll frame
    assert_link_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && !own_cpu) |=> $stable(link_up));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int DIV_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIV_W-1:0]         mdc_div,
    input  logic                     cmd_start,
    input  logic                     cmd_rd,
    input  logic [PHY_AW-1:0]        cmd_phy,
    input  logic [REG_AW-1:0]        cmd_reg,
    input  logic [DATA_W-1:0]        cmd_wdata,
    input  logic [NPORTS*PHY_AW-1:0] poll_phy_addr,
    input  logic                     mdio_in,
    output logic                     mdc,
    output logic                     mdio_out,
    output logic                     mdio_oe,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     busy,
    output logic [NPORTS-1:0]        link_up
);

    logic              rise_stb;
    logic              fall_stb;
    logic              accept;
    logic              done;
    logic [DATA_W-1:0] rd_word;
    mgmt_req_t         req;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .div_half (mdc_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_sched #(.NPORTS(NPORTS)) u_sched (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cmd_rd        (cmd_rd),
        .cmd_phy       (cmd_phy),
        .cmd_reg       (cmd_reg),
        .cmd_wdata     (cmd_wdata),
        .poll_phy_addr (poll_phy_addr),
        .accept        (accept),
        .done          (done),
        .rd_word       (rd_word),
        .req           (req),
        .busy          (busy),
        .rd_data       (rd_data),
        .link_up       (link_up)
    );

    // The scheduler always offers a request: a command or the next poll.
    mdio_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .fall_stb  (fall_stb),
        .rise_stb  (rise_stb),
        .req_valid (1'b1),
        .req       (req),
        .mdio_in   (mdio_in),
        .accept    (accept),
        .done      (done),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rd_word   (rd_word)
    );

    // R10: quiet outputs while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R10: assert (!busy || $time == 0);
        end
    end

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 3;
    localparam int DW         = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DW-1:0]     mdc_div = 8'd1;
    logic              cmd_start = 1'b0;
    logic              cmd_rd = 1'b0;
    logic [4:0]        cmd_phy = '0;
    logic [4:0]        cmd_reg = '0;
    logic [15:0]       cmd_wdata = '0;
    logic [NP-1:0][4:0] paddr = '0;
    logic              mdio_in = 1'b1;
    logic              mdc, mdio_out, mdio_oe, busy;
    logic [15:0]       rd_data;
    logic [NP-1:0]     link_up;

    int checks = 0;
    int fails  = 0;
    int starts = 0;
    int frames = 0;
    int last_start = 0;
    logic [63:0] last_fb = '0;
    logic [31:0] link_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.NPORTS(NP), .DIV_W(DW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .mdc_div       (mdc_div),
        .cmd_start     (cmd_start),
        .cmd_rd        (cmd_rd),
        .cmd_phy       (cmd_phy),
        .cmd_reg       (cmd_reg),
        .cmd_wdata     (cmd_wdata),
        .poll_phy_addr (paddr),
        .mdio_in       (mdio_in),
        .mdc           (mdc),
        .mdio_out      (mdio_out),
        .mdio_oe       (mdio_oe),
        .rd_data       (rd_data),
        .busy          (busy),
        .link_up       (link_up)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // PHY register contents seen by the master
    function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] r);
        if (r == 5'd1) return 16'h7809 | (16'(link_model[p]) << 2);
        return {p, r, 6'h2A} ^ 16'hA5C3;
    endfunction

    // Frame monitor and PHY responder
    initial begin
        logic [63:0] fb, fo;
        logic [15:0] rsp;
        int my_start;
        forever begin
            @(posedge mdio_oe);
            starts++;
            my_start = starts;
            fb = '0;
            fo = '0;
            rsp = '0;
            for (int i = 0; i < 64; i++) begin
                @(posedge mdc);
                #1;
                fb[63-i] = mdio_out;
                fo[63-i] = mdio_oe;
                if (i == 45) rsp = phy_val(fb[27:23], fb[22:18]);
                if (i >= 46 && i <= 62 && fb[29:28] == 2'b10) begin
                    @(negedge mdc);
                    #1;
                    if (i + 1 == 47) mdio_in = 1'b0;
                    else mdio_in = rsp[15-(i+1-48)];
                end
            end
            chk(fb[63:32] == '1 && fo[63:32] == '1, "R1 preamble", fb[63:32], 32'hFFFFFFFF);
            chk(fb[31:30] == 2'b01 && (fb[29:28] == 2'b10 || fb[29:28] == 2'b01),
                "R2 start/opcode", fb[31:28], 32'h6);
            if (fb[29:28] == 2'b10)
                chk(fo[63:18] == '1 && fo[17:0] == '0, "R5 read release", fo[31:0], 32'hFFFC0000);
            else
                chk(fb[17:16] == 2'b10 && fo == '1, "R4 write turnaround", {fb[17:16], fo[31:0] == '1}, 32'h5);
            last_fb = fb;
            last_start = my_start;
            frames++;
            @(negedge mdc);
            #1;
            mdio_in = 1'b1;
            @(posedge mdc);
            #1;
            chk(!mdio_oe, "R11 idle gap", mdio_oe, 0);
        end
    end

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(negedge clk);
    endtask

    task automatic issue(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] wd);
        @(negedge clk);
        cmd_rd = rd; cmd_phy = p; cmd_reg = r; cmd_wdata = wd; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy, "R7 busy rises", busy, 1);
    endtask

    task automatic finish_and_check(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] wd);
        while (busy) @(negedge clk);
        chk(last_fb[27:23] == p && last_fb[22:18] == r, "R3 addresses",
            {last_fb[27:23], last_fb[22:18]}, {p, r});
        chk(last_fb[29:28] == (rd ? 2'b10 : 2'b01), "R2 opcode", last_fb[29:28], rd ? 2 : 1);
        if (rd) chk(rd_data == phy_val(p, r), "R5 read data", rd_data, phy_val(p, r));
        else    chk(last_fb[15:0] == wd, "R4 write data", last_fb[15:0], wd);
    endtask

    task automatic measure_mdc(input logic [DW-1:0] d);
        int n;
        mdc_div = d;
        repeat (3) @(posedge mdc);
        @(posedge mdc);
        @(negedge clk);
        n = 1;
        while (mdc) begin
            @(negedge clk);
            if (mdc) n++;
        end
        chk(n == int'(d) + 1, "R6 mdc half period", n, int'(d) + 1);
    endtask

    task automatic link_round(input int off);
        for (int p = 0; p < NP; p++) paddr[p] = 5'((p * 7 + off) % 32);
        link_model = $urandom();
        wait_frames(2 * NP + 2);
        for (int p = 0; p < NP; p++)
            chk(link_up[p] == link_model[paddr[p]], "R8 link bit", link_up[p], link_model[paddr[p]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(!mdc && !mdio_oe && !busy, "R10 reset controls", {mdc, mdio_oe, busy}, 0);
        chk(link_up == '0 && rd_data == '0, "R10 reset data", {link_up, rd_data}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R6: divider settings
        measure_mdc(8'd0);
        measure_mdc(8'd3);
        measure_mdc(8'd1);

        // R8: polling across ports
        link_round(3);
        link_round(17);

        // Directed read and write at extreme addresses
        issue(1'b1, 5'd31, 5'd31, 16'h0);
        finish_and_check(1'b1, 5'd31, 5'd31, 16'h0);
        issue(1'b0, 5'd0, 5'd0, 16'h8001);
        finish_and_check(1'b0, 5'd0, 5'd0, 16'h8001);

        // R9: command during a poll frame takes the next slot
        begin
            int s;
            @(posedge mdio_oe);
            repeat (10) @(negedge clk);
            s = starts;
            issue(1'b1, 5'd9, 5'd4, 16'h0);
            finish_and_check(1'b1, 5'd9, 5'd4, 16'h0);
            chk(last_start == s + 1, "R9 next slot", last_start, s + 1);
        end

        // R7: a second strobe while busy is ignored
        begin
            int rises;
            issue(1'b0, 5'd12, 5'd6, 16'hBEEF);
            repeat (4) @(negedge clk);
            cmd_rd = 1'b1; cmd_phy = 5'd20; cmd_reg = 5'd2; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            finish_and_check(1'b0, 5'd12, 5'd6, 16'hBEEF);
            rises = 0;
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                if (busy) rises++;
            end
            chk(rises == 0, "R7 ignored strobe", rises, 0);
        end

        // Constrained random commands with varying divider
        for (int t = 0; t < 12; t++) begin
            bit rd;
            logic [4:0] p, r;
            logic [15:0] wd;
            rd = 1'($urandom_range(0, 1));
            p  = 5'($urandom());
            r  = 5'($urandom());
            wd = 16'($urandom());
            mdc_div = DW'($urandom_range(0, 2));
            link_model = $urandom();
            issue(rd, p, r, wd);
            finish_and_check(rd, p, r, wd);
        end

        link_round(25);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule